// File: doc/BRIEF.md
# Beam-Synchronised Display List Engine

This block walks a list of 32-bit instructions held in memory, reading each one as two 16-bit words, and carries them out in lock-step with the video beam position. A MOVE instruction writes a 16-bit value into a register of a memory-mapped register file through an offset-and-data write port. A WAIT instruction stalls the engine until the beam has reached a masked compare position. This lets software change display registers at chosen points on the screen without CPU involvement.

The list start address is wider than a 16-bit word. Software loads it as two halves. Execution begins at that address whenever a start strobe arrives. It also begins again at the top of every frame, which is the moment the vertical beam counter returns to zero. A reserved word pair ends the list, and the engine then stays idle until the next restart.

Top module: `dlist_engine`

## Requirements
- R1: While reset is held and after it is released, the engine issues no memory request and no register write until a start strobe or a frame start occurs.
- R2: In the cycle after a start strobe, the engine requests memory at the list pointer. The pointer is loaded from two halves: `ptr_hi`=1 writes address bits above 15, and `ptr_hi`=0 writes bits 15:0 with bit 0 forced to 0.
- R3: Each instruction is fetched as word 0 at the program counter and word 1 at the program counter plus 2. Each request lasts one cycle, and its data is taken in the cycle that `mem_valid` is high.
- R4: When bit 0 of word 0 is 0, the instruction is a MOVE. It drives `reg_we` high for one cycle with `reg_off` = word 0 bits 7:0 (always even) and `reg_wdata` = word 1. The next instruction is then fetched at the program counter plus 4.
- R5: When bit 0 of word 0 is 1 and bit 0 of word 1 is 0, the instruction is a WAIT. The engine stalls with no fetch and no write until {V & VM, H[7:1] & HM} >= {word0[15:8] & VM, word0[7:1] & HM}, with VM = {1, word1[14:8]} and HM = word1[7:1].
- R6: The WAIT compare treats the vertical position as the more significant part. A greater vertical position satisfies the WAIT whatever the horizontal position is.
- R7: Mask bits that are 0 remove the matching beam and compare bits from the WAIT test, so a beam position that is greater before masking can still stall.
- R8: When bit 0 of both words is 1, the instruction is a SKIP. It writes nothing, and execution continues with the next instruction.
- R9: The word pair 0xFFFF, 0xFFFE ends the list. After it, no fetch and no write occur until a restart.
- R10: When `beam_v` changes from nonzero to zero, execution restarts at the list pointer.
- R11: A start strobe restarts execution at the list pointer even while a WAIT is pending, and the abandoned instruction is never executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart strobe |
| ptr_we | input | 1 | List pointer half write enable |
| ptr_hi | input | 1 | 1 selects the upper half, 0 the lower half |
| ptr_wdata | input | 16 | List pointer half data |
| beam_v | input | 8 | Vertical beam position |
| beam_h | input | 8 | Horizontal beam position |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| reg_we | output | 1 | Register write strobe |
| reg_off | output | 8 | Register offset from the register-file base |
| reg_wdata | output | 16 | Register write data |

## Verification
The hardest case to reach from the ports is a WAIT that the masks keep stalled even though the unmasked beam position is already past the target. Equally hard is telling a vertical-first compare apart from a horizontal one. The bench controls the beam counters directly and steps them to chosen positions while a WAIT is pending. It holds each position long enough to show that no write leaks out, and only then moves the beam across the masked threshold. Restart during a pending WAIT is reached by starting a list whose WAIT cannot yet be met, then repointing and strobing start.

// File: rtl/dlist_pkg.sv
package dlist_pkg;

    localparam logic [15:0] END_W0 = 16'hFFFF;
    localparam logic [15:0] END_W1 = 16'hFFFE;

    typedef enum logic [2:0] {
        S_HALT, S_REQ0, S_RSP0, S_REQ1, S_RSP1, S_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_MOVE, OP_WAIT, OP_SKIP, OP_END
    } op_t;

    typedef struct packed {
        logic [15:0] w0;
        logic [15:0] w1;
    } instr_t;

    function automatic op_t decode_op(instr_t i);
        if (!i.w0[0])                               return OP_MOVE;
        else if (i.w0 == END_W0 && i.w1 == END_W1)  return OP_END;
        else if (i.w1[0])                           return OP_SKIP;
        else                                        return OP_WAIT;
    endfunction

endpackage

// File: rtl/dlist_ptr.sv
module dlist_ptr #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_we,
    input  logic              ptr_hi,
    input  logic [15:0]       ptr_wdata,
    output logic [ADDR_W-1:0] list_ptr
);
    localparam int HI_W = ADDR_W - 16;

    logic [HI_W-1:0] hi_q;
    logic [15:0]     lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (ptr_we) begin
            if (ptr_hi) hi_q <= ptr_wdata[HI_W-1:0];
            else        lo_q <= {ptr_wdata[15:1], 1'b0};
        end
    end

    assign list_ptr = {hi_q, lo_q};
endmodule

// File: rtl/dlist_beam_cmp.sv
module dlist_beam_cmp
    import dlist_pkg::*;
(
    input  logic [7:0] beam_v,
    input  logic [7:0] beam_h,
    input  instr_t     instr,
    output logic       reached
);
    logic [7:0]  vmask;
    logic [6:0]  hmask;
    logic [14:0] beam_pos;
    logic [14:0] target_pos;

    always_comb begin
        vmask      = {1'b1, instr.w1[14:8]};
        hmask      = instr.w1[7:1];
        beam_pos   = {beam_v & vmask, beam_h[7:1] & hmask};
        target_pos = {instr.w0[15:8] & vmask, instr.w0[7:1] & hmask};
        reached    = (beam_pos >= target_pos);
    end
endmodule

// File: rtl/dlist_seq.sv
module dlist_seq
    import dlist_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [ADDR_W-1:0] list_ptr,
    input  logic              reached,
    input  logic              mem_valid,
    input  logic [15:0]       mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output instr_t            instr,
    output seq_state_t        state,
    output logic              reg_we,
    output logic [7:0]        reg_off,
    output logic [15:0]       reg_wdata
);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_PAIR = ADDR_W'(4);

    logic [ADDR_W-1:0] pc;
    instr_t            fetched;

    assign fetched  = '{w0: instr.w0, w1: mem_rdata};
    assign mem_req  = (state == S_REQ0) || (state == S_REQ1);
    assign mem_addr = (state == S_REQ1) ? pc + STEP_WORD : pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_HALT;
            pc        <= '0;
            instr     <= '0;
            reg_we    <= 1'b0;
            reg_off   <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (restart) begin
                pc    <= list_ptr;
                state <= S_REQ0;
            end else begin
                case (state)
                    S_REQ0: state <= S_RSP0;
                    S_RSP0: if (mem_valid) begin
                        instr.w0 <= mem_rdata;
                        state    <= S_REQ1;
                    end
                    S_REQ1: state <= S_RSP1;
                    S_RSP1: if (mem_valid) begin
                        instr.w1 <= mem_rdata;
                        case (decode_op(fetched))
                            OP_MOVE: begin
                                reg_we    <= 1'b1;
                                reg_off   <= instr.w0[7:0];
                                reg_wdata <= mem_rdata;
                                pc        <= pc + STEP_PAIR;
                                state     <= S_REQ0;
                            end
                            OP_SKIP: begin
                                pc    <= pc + STEP_PAIR;
                                state <= S_REQ0;
                            end
                            OP_WAIT: begin
                                pc    <= pc + STEP_PAIR;
                                state <= S_WAIT;
                            end
                            default: state <= S_HALT;
                        endcase
                    end
                    S_WAIT: if (reached) state <= S_REQ0;
                    default: state <= S_HALT;
                endcase
            end
        end
    end
endmodule

// File: rtl/dlist_engine.sv
module dlist_engine
    import dlist_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ptr_we,
    input  logic              ptr_hi,
    input  logic [15:0]       ptr_wdata,
    input  logic [7:0]        beam_v,
    input  logic [7:0]        beam_h,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [15:0]       mem_rdata,
    output logic              reg_we,
    output logic [7:0]        reg_off,
    output logic [15:0]       reg_wdata
);
    logic [ADDR_W-1:0] list_ptr;
    logic              prev_v_zero;
    logic              frame_start;
    logic              restart;
    logic              reached;
    instr_t            instr;
    seq_state_t        seq_state;

    always_ff @(posedge clk) prev_v_zero <= (beam_v == '0);

    assign frame_start = (beam_v == '0) && !prev_v_zero;
    assign restart     = start || frame_start;

    dlist_ptr #(.ADDR_W(ADDR_W)) i_ptr (
        .clk(clk), .rst(rst), .ptr_we(ptr_we), .ptr_hi(ptr_hi),
        .ptr_wdata(ptr_wdata), .list_ptr(list_ptr)
    );

    dlist_beam_cmp i_cmp (
        .beam_v(beam_v), .beam_h(beam_h), .instr(instr), .reached(reached)
    );

    dlist_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk(clk), .rst(rst), .restart(restart), .list_ptr(list_ptr),
        .reached(reached), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .instr(instr),
        .state(seq_state), .reg_we(reg_we), .reg_off(reg_off),
        .reg_wdata(reg_wdata)
    );
endmodule

// File: rtl/dlist_engine_chk.sv
module dlist_engine_chk
    import dlist_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [7:0]        beam_v,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic              reg_we,
    input logic [7:0]        reg_off,
    input logic [ADDR_W-1:0] list_ptr,
    input logic              restart,
    input logic              reached,
    input seq_state_t        seq_state
);
    a_r2_start_fetch: assert property (@(posedge clk) disable iff (rst)
        start |=> (mem_req && mem_addr == $past(list_ptr)));

    a_r10_frame_restart: assert property (@(posedge clk) disable iff (rst)
        (beam_v == 8'd0 && $past(beam_v) != 8'd0) |=> (mem_req && mem_addr == $past(list_ptr)));

    a_r5_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (seq_state == S_WAIT && !reached && !restart) |=> (seq_state == S_WAIT && !mem_req && !reg_we));

    a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    a_r4_even_offset: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !reg_off[0]);

    a_r3_write_after_data: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(mem_valid));

    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        (seq_state == S_HALT && !restart) |=> (!mem_req && !reg_we));
endmodule

bind dlist_engine dlist_engine_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .start(start), .beam_v(beam_v),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .reg_we(reg_we), .reg_off(reg_off), .list_ptr(list_ptr),
    .restart(restart), .reached(reached), .seq_state(seq_state)
);

// File: tb/test_dlist_engine.sv
module test_dlist_engine;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              ptr_we = 1'b0;
    logic              ptr_hi = 1'b0;
    logic [15:0]       ptr_wdata = '0;
    logic [7:0]        beam_v = 8'h10;
    logic [7:0]        beam_h = 8'h00;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_valid = 1'b0;
    logic [15:0]       mem_rdata = '0;
    logic              reg_we;
    logic [7:0]        reg_off;
    logic [15:0]       reg_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0]  off;
        logic [15:0] data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [15:0] mem [64];

    always #5 clk = ~clk;

    dlist_engine #(.ADDR_W(ADDR_W)) i_dlist_engine (
        .clk(clk), .rst(rst), .start(start), .ptr_we(ptr_we), .ptr_hi(ptr_hi),
        .ptr_wdata(ptr_wdata), .beam_v(beam_v), .beam_h(beam_h),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_off(reg_off),
        .reg_wdata(reg_wdata)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_valid <= mem_req;
        mem_rdata <= mem[mem_addr[6:1]];
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: pops scoreboard on every register write
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R5/R8/R9", "unexpected register write",
                    {8'h0, reg_off, reg_wdata}, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(reg_off == e.off && reg_wdata == e.data, e.tag, "move write",
                    {8'h0, reg_off, reg_wdata}, {8'h0, e.off, e.data});
            end
        end
    end

    task automatic expect_move(input logic [15:0] w0, input logic [15:0] w1, input string tag);
        exp_t e;
        e.off = w0[7:0];
        e.data = w1;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic put(input int idx, input logic [15:0] w0, input logic [15:0] w1);
        mem[idx]   = w0;
        mem[idx+1] = w1;
    endtask

    task automatic set_ptr(input logic [15:0] hi, input logic [15:0] lo);
        @(negedge clk);
        ptr_we = 1'b1; ptr_hi = 1'b1; ptr_wdata = hi;
        @(negedge clk);
        ptr_hi = 1'b0; ptr_wdata = lo;
        @(negedge clk);
        ptr_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sb_empty(input string tag);
        chk(sb.size() == 0, tag, "expected writes outstanding", sb.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        // list A at byte 0x20 (word 16)
        put(16, 16'h0180, 16'h0F00);
        put(18, 16'h0182, 16'h1234);
        put(20, 16'h3001, 16'hFFFE);
        put(22, 16'h0184, 16'hBEEF);
        put(24, 16'h0001, 16'h0001);   // SKIP
        put(26, 16'h0186, 16'h5555);
        put(28, 16'hFFFF, 16'hFFFE);   // end
        put(30, 16'h0188, 16'hDEAD);   // must never run
        // list B at byte 0x40 (word 32)
        put(32, 16'h0501, 16'h0FFE);   // vertical mask 0x8F
        put(34, 16'h0190, 16'hAAAA);
        put(36, 16'h2541, 16'hFFFE);
        put(38, 16'h0192, 16'h0001);
        put(40, 16'h2881, 16'hFFFE);
        put(42, 16'h0194, 16'h0002);
        put(44, 16'hFFFF, 16'hFFFE);
        // list C at byte 0x60 (word 48)
        put(48, 16'h019A, 16'h0777);
        put(50, 16'hFFFF, 16'hFFFE);
        // list D at byte 0x68 (word 52)
        put(52, 16'h7001, 16'hFFFE);
        put(54, 16'h019C, 16'h0101);
        put(56, 16'hFFFF, 16'hFFFE);

        idle(3);
        chk(mem_req == 1'b0 && reg_we == 1'b0, "R1", "quiet in reset",
            {mem_req, reg_we}, 0);
        @(negedge clk);
        rst = 1'b0;
        idle(10);
        chk(mem_req == 1'b0 && reg_we == 1'b0, "R1", "idle after reset",
            {mem_req, reg_we}, 0);

        // R2: pointer halves, first fetch address
        set_ptr(16'h0005, 16'h0021);
        expect_move(16'h0180, 16'h0F00, "R4");
        expect_move(16'h0182, 16'h1234, "R3");
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_req && mem_addr == 20'h50020, "R2", "first fetch address",
            {11'h0, mem_req, mem_addr}, {11'h0, 1'b1, 20'h50020});
        idle(30);
        sb_empty("R4");
        // R5: beam below 0x30, WAIT must still hold
        chk(mem_req == 1'b0, "R5", "no fetch while waiting", mem_req, 0);
        beam_v = 8'h2F; beam_h = 8'hFF;
        idle(20);
        chk(mem_req == 1'b0, "R5", "still waiting at 2F/FF", mem_req, 0);
        expect_move(16'h0184, 16'hBEEF, "R5");
        expect_move(16'h0186, 16'h5555, "R8");
        beam_v = 8'h30; beam_h = 8'h00;
        idle(40);
        sb_empty("R8");
        chk(mem_req == 1'b0, "R9", "halted after end pair", mem_req, 0);

        // R11: restart abandons a pending WAIT
        beam_v = 8'h50;
        set_ptr(16'h0000, 16'h0068);
        pulse_start();
        idle(30);
        chk(mem_req == 1'b0, "R11", "list D waiting", mem_req, 0);
        set_ptr(16'h0000, 16'h0060);
        expect_move(16'h019A, 16'h0777, "R11");
        pulse_start();
        idle(30);
        sb_empty("R11");
        beam_v = 8'h70;
        idle(20);
        sb_empty("R11");

        // R10: frame start restarts at pointer (list C)
        expect_move(16'h019A, 16'h0777, "R10");
        beam_v = 8'h00;
        idle(30);
        sb_empty("R10");
        beam_v = 8'h05;
        idle(5);
        expect_move(16'h019A, 16'h0777, "R10");
        beam_v = 8'h00;
        idle(30);
        sb_empty("R10");

        // R7/R6: masked and vertical-first compares (list B)
        beam_v = 8'h13; beam_h = 8'h00;
        set_ptr(16'h0000, 16'h0040);
        pulse_start();
        idle(30);
        chk(mem_req == 1'b0, "R7", "masked vertical holds at 0x13", mem_req, 0);
        expect_move(16'h0190, 16'hAAAA, "R7");
        beam_v = 8'h25; beam_h = 8'h30;
        idle(30);
        sb_empty("R7");
        chk(mem_req == 1'b0, "R5", "horizontal below target", mem_req, 0);
        expect_move(16'h0192, 16'h0001, "R5");
        beam_h = 8'h40;
        idle(30);
        sb_empty("R5");
        expect_move(16'h0194, 16'h0002, "R6");
        beam_v = 8'h29; beam_h = 8'h00;
        idle(30);
        sb_empty("R6");
        chk(mem_req == 1'b0, "R9", "halted after list B", mem_req, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule